// File: doc/BRIEF.md
# Three-Axis Single and Double Tap Detector

The block watches a stream of signed acceleration samples on three axes and decides, per axis, whether a short knock was a single tap or one of a pair. A tap is an excursion of the sample magnitude above a programmable per-axis threshold that returns below it within a bounded number of samples. After a first tap the axis ignores further activity for a latency interval, then opens a window in which a second tap turns the event into a double tap. If no second tap arrives, the single tap is reported when the window closes. Latency and window are counted in ticks of a 1 ms timing strobe. The pulse-length limit is counted in sample periods.

Software configures thresholds, timing and six event enables through a small register port. Qualified events land in a source register whose summary bit drives the interrupt output. In latched mode, events accumulate until the source register is read, and that read clears them. In pass-through mode, each event shows for one sample period.

Top module: `tap_detector`

## Requirements
- R1: After reset every register reads 0x00 and irq_o is low.
- R2: Register addresses are 0 config, 1 source, 2 X/Y thresholds, 3 Z threshold, 4 pulse limit, 5 latency, 6 window. Config bit 7 and Z-threshold bits 7..4 are reserved: writes to them are dropped and they read 0. Writes to the source address have no effect.
- R3: An axis sample counts as above threshold when its magnitude is strictly greater than its nibble times STEP_SCALE (16 by default). The X nibble is in bits 3..0 of address 2, the Y nibble in bits 7..4 of address 2, and the Z nibble in bits 3..0 of address 3. The magnitude of -128 is 128.
- R4: An excursion is a tap only if the number of consecutive above-threshold samples is at most the pulse limit. A longer excursion produces no event.
- R5: After a first tap, excursions that begin and end while the latency count (address 5, in ticks) is still running are ignored.
- R6: An excursion that starts after the latency has elapsed and before the window (address 6, in ticks) has expired, and that qualifies as a tap, reports a double tap. No single tap is reported for that pair.
- R7: A first tap with no qualifying second tap reports a single tap once latency plus window ticks have elapsed.
- R8: If an axis's double-tap enable is clear, a tap on that axis reports a single tap immediately, without waiting for latency or window.
- R9: Config bits 5..0 and source bits 5..0 share one layout: bit 5 double Z, bit 4 single Z, bit 3 double Y, bit 2 single Y, bit 1 double X, bit 0 single X. An event whose enable is clear is never flagged. Source bit 6 is the OR of bits 5..0, and irq_o equals source bit 6.
- R10: With config bit 6 set, flags accumulate until the source register is read. That read returns the flags and clears them.
- R11: With config bit 6 clear, flags are replaced by each new event and cleared by the next valid sample. Reads do not clear them.
- R12: A second excursion inside the window that exceeds the pulse limit leaves the first tap reported as a single tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe for the three axis inputs |
| smp_x_i | input | 8 | Signed X sample |
| smp_y_i | input | 8 | Signed Y sample |
| smp_z_i | input | 8 | Signed Z sample |
| tick_i | input | 1 | 1 ms timing strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe; a read of the source address clears it in latched mode |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt, high while any source flag is set |

## Verification
The bench aims at the boundaries of each timing interval. It places a second excursion one tick before latency ends, exactly when it ends, and one tick before and one tick after the window closes. A design that is off by one tick would report a double where a single is due, or the reverse. It drives pulses exactly at and one sample beyond the pulse limit, and magnitudes equal to and just above the threshold, including -128. A wrong comparison or a truncated absolute value would drop or invent taps. It swaps the X and Y nibble values, clears each enable in turn, and checks clear-on-read against pass-through mode, which catches interleaved bit orders and stale or sticky flags.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_SRC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_THXY = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_THZ  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_TLIM = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_LAT  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 3'd6;

  localparam int CFG_LATCH_BIT = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH1,
    ST_LAT,
    ST_WIN,
    ST_HIGH2
  } tap_st_e;
endpackage

// File: rtl/tap_axis.sv
`timescale 1ns/1ps
module tap_axis
  import tap_pkg::*;
#(
  parameter int SMP_W      = 8,
  parameter int THR_W      = 4,
  parameter int TIME_W     = 8,
  parameter int STEP_SCALE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              tick_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic [TIME_W-1:0] tlim_i,
  input  logic [TIME_W-1:0] lat_i,
  input  logic [TIME_W-1:0] win_i,
  input  logic              dbl_en_i,
  output logic              single_o,
  output logic              double_o
);
  localparam int CMP_W = SMP_W + 1 + THR_W + $clog2(STEP_SCALE + 1);

  logic [SMP_W:0]   s_ext, mag;
  logic [CMP_W-1:0] thr_mag;
  logic             above, hit;
  tap_st_e          st_q;
  logic [TIME_W:0]  pcnt_q;
  logic [TIME_W-1:0] tcnt_q;
  logic             pulse_ok;

  assign s_ext    = {smp_i[SMP_W-1], smp_i};
  assign mag      = s_ext[SMP_W] ? (~s_ext + 1'b1) : s_ext;
  assign thr_mag  = CMP_W'(thr_i) * CMP_W'(STEP_SCALE);
  assign above    = CMP_W'(mag) > thr_mag;
  assign hit      = smp_valid_i && above;
  assign pulse_ok = pcnt_q <= {1'b0, tlim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      pcnt_q   <= '0;
      tcnt_q   <= '0;
      single_o <= 1'b0;
      double_o <= 1'b0;
    end else begin
      single_o <= 1'b0;
      double_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (hit) begin
          st_q   <= ST_HIGH1;
          pcnt_q <= TIME_W'(1);
        end
        ST_HIGH1: if (smp_valid_i) begin
          if (above) begin
            if (pcnt_q != '1) pcnt_q <= pcnt_q + 1'b1;
          end else if (!pulse_ok) begin
            st_q <= ST_IDLE;
          end else if (!dbl_en_i) begin
            single_o <= 1'b1;
            st_q     <= ST_IDLE;
          end else begin
            st_q   <= ST_LAT;
            tcnt_q <= '0;
          end
        end
        ST_LAT: begin
          if (tcnt_q == lat_i) begin
            st_q   <= ST_WIN;
            tcnt_q <= '0;
          end else if (tick_i) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_WIN: begin
          if (hit) begin
            st_q   <= ST_HIGH2;
            pcnt_q <= TIME_W'(1);
          end else if (tcnt_q == win_i) begin
            single_o <= 1'b1;
            st_q     <= ST_IDLE;
          end else if (tick_i) begin
            tcnt_q <= tcnt_q + 1'b1;
          end
        end
        ST_HIGH2: if (smp_valid_i) begin
          if (above) begin
            if (pcnt_q != '1) pcnt_q <= pcnt_q + 1'b1;
          end else begin
            // overlong second pulse keeps the first tap as a single
            double_o <= pulse_ok;
            single_o <= !pulse_ok;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r6_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_o && double_o));
  a_r5_latency_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LAT) |=> (!single_o && !double_o));
  a_r6_double_from_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(double_o) |-> ($past(st_q) == ST_HIGH2));
endmodule

// File: rtl/tap_regs.sv
`timescale 1ns/1ps
module tap_regs
  import tap_pkg::*;
#(
  parameter int THR_W  = 4,
  parameter int TIME_W = 8,
  parameter int N_AX   = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         re_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  input  logic                         smp_valid_i,
  input  logic [N_AX-1:0]              single_i,
  input  logic [N_AX-1:0]              double_i,
  output logic [REG_W-1:0]             rdata_o,
  output logic                         irq_o,
  output logic [N_AX-1:0][THR_W-1:0]   thr_o,
  output logic [TIME_W-1:0]            tlim_o,
  output logic [TIME_W-1:0]            lat_o,
  output logic [TIME_W-1:0]            win_o,
  output logic [N_AX-1:0]              dbl_en_o
);
  localparam int NF = 2 * N_AX;

  logic [NF:0]        cfg_q;
  logic [NF-1:0]      flags_q, ev_raw, ev;
  logic [2*THR_W-1:0] thr_xy_q;
  logic [THR_W-1:0]   thr_z_q;
  logic               latch, rd_src, cfg_wr;

  for (genvar a = 0; a < N_AX; a++) begin : g_ev
    assign ev_raw[2*a]   = single_i[a];
    assign ev_raw[2*a+1] = double_i[a];
    assign dbl_en_o[a]   = cfg_q[2*a+1];
  end

  assign ev     = ev_raw & cfg_q[NF-1:0];
  assign latch  = cfg_q[CFG_LATCH_BIT];
  assign rd_src = re_i && (addr_i == ADDR_SRC);
  assign cfg_wr = we_i && (addr_i == ADDR_CFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      thr_xy_q <= '0;
      thr_z_q  <= '0;
      tlim_o   <= '0;
      lat_o    <= '0;
      win_o    <= '0;
    end else if (we_i) begin
      case (addr_i)
        ADDR_CFG:  cfg_q    <= wdata_i[NF:0];
        ADDR_THXY: thr_xy_q <= wdata_i[2*THR_W-1:0];
        ADDR_THZ:  thr_z_q  <= wdata_i[THR_W-1:0];
        ADDR_TLIM: tlim_o   <= wdata_i[TIME_W-1:0];
        ADDR_LAT:  lat_o    <= wdata_i[TIME_W-1:0];
        ADDR_WIN:  win_o    <= wdata_i[TIME_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else if (latch) begin
      flags_q <= (rd_src ? '0 : flags_q) | ev;
    end else if (|ev) begin
      flags_q <= ev;
    end else if (smp_valid_i) begin
      flags_q <= '0;
    end
  end

  assign thr_o[0] = thr_xy_q[THR_W-1:0];
  assign thr_o[1] = thr_xy_q[2*THR_W-1:THR_W];
  assign thr_o[2] = thr_z_q;
  assign irq_o    = |flags_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CFG:  rdata_o = REG_W'(cfg_q);
      ADDR_SRC:  rdata_o = REG_W'({irq_o, flags_q});
      ADDR_THXY: rdata_o = REG_W'(thr_xy_q);
      ADDR_THZ:  rdata_o = REG_W'(thr_z_q);
      ADDR_TLIM: rdata_o = REG_W'(tlim_o);
      ADDR_LAT:  rdata_o = REG_W'(lat_o);
      ADDR_WIN:  rdata_o = REG_W'(win_o);
      default:   rdata_o = '0;
    endcase
  end

  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch && rd_src && !cfg_wr && (ev_raw == '0)) |=> (flags_q == '0));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch && !rd_src && !cfg_wr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r11_drop_on_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch && smp_valid_i && !cfg_wr && (ev_raw == '0)) |=> (flags_q == '0));
endmodule

// File: rtl/tap_detector.sv
`timescale 1ns/1ps
module tap_detector
  import tap_pkg::*;
#(
  parameter int SMP_W      = 8,
  parameter int THR_W      = 4,
  parameter int TIME_W     = 8,
  parameter int STEP_SCALE = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_x_i,
  input  logic [SMP_W-1:0]  smp_y_i,
  input  logic [SMP_W-1:0]  smp_z_i,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int N_AX = 3;

  logic [N_AX-1:0][SMP_W-1:0] smp;
  logic [N_AX-1:0][THR_W-1:0] thr;
  logic [TIME_W-1:0]          tlim, lat, win;
  logic [N_AX-1:0]            dbl_en, single_ev, double_ev;

  assign smp = {smp_z_i, smp_y_i, smp_x_i};

  for (genvar a = 0; a < N_AX; a++) begin : g_axis
    tap_axis #(
      .SMP_W(SMP_W), .THR_W(THR_W), .TIME_W(TIME_W), .STEP_SCALE(STEP_SCALE)
    ) u_axis (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .smp_valid_i(smp_valid_i),
      .smp_i      (smp[a]),
      .tick_i     (tick_i),
      .thr_i      (thr[a]),
      .tlim_i     (tlim),
      .lat_i      (lat),
      .win_i      (win),
      .dbl_en_i   (dbl_en[a]),
      .single_o   (single_ev[a]),
      .double_o   (double_ev[a])
    );
  end

  tap_regs #(.THR_W(THR_W), .TIME_W(TIME_W), .N_AX(N_AX)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .re_i       (reg_re_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .smp_valid_i(smp_valid_i),
    .single_i   (single_ev),
    .double_i   (double_ev),
    .rdata_o    (reg_rdata_o),
    .irq_o      (irq_o),
    .thr_o      (thr),
    .tlim_o     (tlim),
    .lat_o      (lat),
    .win_o      (win),
    .dbl_en_o   (dbl_en)
  );
endmodule

// File: tb/tap_detector_bench.sv
`timescale 1ns/1ps
module tap_detector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 13;
  localparam int CLOSE_TICKS = 8;

  typedef struct packed {
    logic [1:0] axis;
    logic [7:0] amp;
    logic [3:0] len1;
    logic [3:0] gap;
    logic [3:0] len2;
    logic [7:0] exp_src;
  } vec_t;

  // thr X=32, Y=48, Z=48; limit 3 samples; latency 2; window 4; latched, all enabled
  localparam vec_t VECS [NVEC] = '{
    {2'd0, 8'd50,   4'd2, 4'd0, 4'd0, 8'h41},  // R7 single X
    {2'd1, 8'hC4,   4'd3, 4'd0, 4'd0, 8'h44},  // R4 at limit, R3 negative Y
    {2'd2, 8'd60,   4'd1, 4'd3, 4'd2, 8'h60},  // R6 double Z
    {2'd0, 8'd50,   4'd4, 4'd0, 4'd0, 8'h00},  // R4 overlong
    {2'd0, 8'd40,   4'd1, 4'd1, 4'd1, 8'h41},  // R5 inside latency
    {2'd1, 8'd50,   4'd1, 4'd2, 4'd1, 8'h48},  // R6 right at latency end
    {2'd1, 8'd50,   4'd1, 4'd5, 4'd1, 8'h48},  // R6 last window tick
    {2'd0, 8'd50,   4'd1, 4'd6, 4'd1, 8'h41},  // R7 window closed
    {2'd2, 8'd48,   4'd1, 4'd0, 4'd0, 8'h00},  // R3 equal to threshold
    {2'd2, 8'hCF,   4'd1, 4'd0, 4'd0, 8'h50},  // R3 -49 single Z
    {2'd1, 8'd50,   4'd1, 4'd3, 4'd4, 8'h44},  // R12 overlong second
    {2'd0, 8'h80,   4'd1, 4'd0, 4'd0, 8'h41},  // R3 -128
    {2'd1, 8'd40,   4'd1, 4'd0, 4'd0, 8'h00}   // R3 Y nibble position
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, tick = 1'b0, we = 1'b0, re = 1'b0;
  logic [7:0] sx = '0, sy = '0, sz = '0, wdata = '0;
  logic [2:0] addr = '0;
  logic [7:0] rdata;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tap_detector u_tap_detector (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid),
    .smp_x_i(sx), .smp_y_i(sy), .smp_z_i(sz), .tick_i(tick),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] x, logic [7:0] y, logic [7:0] z);
    @(negedge clk); valid = 1'b1; sx = x; sy = y; sz = z;
    @(negedge clk); valid = 1'b0; sx = '0; sy = '0; sz = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse(logic [1:0] ax, logic [7:0] amp, int len);
    for (int i = 0; i < len; i++)
      send(ax == 2'd0 ? amp : 8'd0, ax == 2'd1 ? amp : 8'd0, ax == 2'd2 ? amp : 8'd0);
    send(8'd0, 8'd0, 8'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      check("R1 reset register", d, 8'h00);
    end
    #1 check("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 reserved bits and readback
    wr(3'd0, 8'hFF); rd(3'd0, d); check("R2 config reserved bit", d, 8'h7F);
    wr(3'd3, 8'hF3); rd(3'd3, d); check("R2 Z threshold reserved nibble", d, 8'h03);
    wr(3'd2, 8'h32); rd(3'd2, d); check("R2 X/Y threshold readback", d, 8'h32);
    wr(3'd1, 8'h7F); rd(3'd1, d); check("R2 source write ignored", d, 8'h00);
    wr(3'd4, 8'd3); wr(3'd5, 8'd2); wr(3'd6, 8'd4);
    rd(3'd6, d); check("R2 window readback", d, 8'h04);
    wr(3'd0, 8'h7F);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      pulse(VECS[v].axis, VECS[v].amp, int'(VECS[v].len1));
      if (VECS[v].len2 != 0) begin
        ticks(int'(VECS[v].gap));
        pulse(VECS[v].axis, VECS[v].amp, int'(VECS[v].len2));
      end
      ticks(CLOSE_TICKS);
      #1 check($sformatf("R9 irq vector %0d", v), {7'd0, irq}, {7'd0, VECS[v].exp_src != 0});
      rd(3'd1, d);
      check($sformatf("R6/R7 source vector %0d", v), d, VECS[v].exp_src);
      rd(3'd1, d);
      check($sformatf("R10 cleared vector %0d", v), d, 8'h00);
    end

    // R8 double disabled: immediate single, no later event
    wr(3'd0, 8'h55);
    pulse(2'd0, 8'd50, 1);
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R8 immediate single X", d, 8'h41);
    ticks(CLOSE_TICKS);
    rd(3'd1, d); check("R8 nothing later", d, 8'h00);

    // R9 single disabled, double enabled
    wr(3'd0, 8'h6A);
    pulse(2'd0, 8'd50, 1);
    ticks(CLOSE_TICKS);
    #1 check("R9 masked single irq", {7'd0, irq}, 8'h00);
    rd(3'd1, d); check("R9 masked single", d, 8'h00);
    pulse(2'd0, 8'd50, 1); ticks(3); pulse(2'd0, 8'd50, 1);
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R9 double X bit 1", d, 8'h42);

    // R10 accumulation across axes
    wr(3'd0, 8'h55);
    pulse(2'd0, 8'd50, 1);
    pulse(2'd2, 8'd60, 1);
    repeat (2) @(negedge clk);
    rd(3'd1, d); check("R10 accumulate X and Z", d, 8'h51);

    // R11 pass-through mode
    wr(3'd0, 8'h3F);
    pulse(2'd0, 8'd50, 1);
    ticks(CLOSE_TICKS);
    rd(3'd1, d); check("R11 flag held", d, 8'h41);
    rd(3'd1, d); check("R11 read does not clear", d, 8'h41);
    #1 check("R11 irq high", {7'd0, irq}, 8'h01);
    send(8'd0, 8'd0, 8'd0);
    rd(3'd1, d); check("R11 cleared by sample", d, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule